// File: doc/BRIEF.md
# Serial Command CRC7 Unit

This block computes and emits the 7-bit checksum used on the command line of an SD-style host. Message bits arrive one per strobe, in the order they go onto the line. They are folded into a seven-stage feedback shift register that divides by x^7 + x^3 + 1. A synchronous clear starts a new frame. A parallel 7-bit view of the register lets the host compare the checksum of a received response against the value carried in that response.

Once the last message bit has been absorbed, the host raises the zero-feed control. Each later strobe then moves the register one place towards its top stage, with the feedback path gated off. The serial output always shows the top stage, so the checksum leaves MSB first over seven strobes and can be appended straight to the outgoing command frame. After those seven strobes the register holds zero.

Top module: `crc7_serial_unit`

## Requirements
- R1: While reset is asserted and after reset is released, `crc_o` is 7'h00 and `ser_o` is 0.
- R2: With `zero_i` low, each cycle with `en_i` high takes `bit_i` as the next message bit, first bit as the highest-order coefficient. After a frame, `crc_o` equals the remainder of message·x^7 divided by x^7 + x^3 + 1. Examples: 40-bit frame 0x4000000000 gives 7'h4A, 0x48000001AA gives 7'h43, 0x5100000000 gives 7'h2A, and 0x7700000000 gives 7'h32.
- R3: `crc_o` is registered. It shows the effect of a strobe in the cycle after the clock edge that samples that strobe, and not before.
- R4: In a cycle with `en_i` low and `clr_i` low, `crc_o` and `ser_o` do not change, whatever `bit_i` and `zero_i` do.
- R5: `clr_i` high sets all seven stages to zero at the next clock edge. This takes priority over a data strobe and over a zero-feed strobe in the same cycle.
- R6: With `zero_i` high, a strobe moves `crc_o` one place up and puts 0 into bit 0, so the new value is {crc_o[5:0], 1'b0}. Seven such strobes leave `crc_o` at 7'h00.
- R7: `ser_o` always equals `crc_o[6]`. When `ser_o` is sampled before each of seven zero-feed strobes, the samples give the checksum MSB first.
- R8: If a message is fed in data mode and then followed by its own 7 checksum bits, MSB first, `crc_o` ends at 7'h00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clr_i | input | 1 | Synchronous clear of the register |
| en_i | input | 1 | Bit strobe; the register moves only on cycles where it is high |
| zero_i | input | 1 | Zero-feed select: shift out instead of absorbing `bit_i` |
| bit_i | input | 1 | Serial message bit |
| ser_o | output | 1 | Serial checksum output (top stage) |
| crc_o | output | 7 | Parallel view of the register |

## Verification
A clear can arrive in the same cycle as a strobe, and that strobe may be either a data strobe or a zero-feed strobe. The bench first loads a known nonzero remainder. It then raises `clr_i` together with `en_i`, once with `bit_i` high in data mode and once with `zero_i` high, and expects `crc_o` to read 7'h00 one cycle later in both cases. A shift or a fed bit would have left a nonzero value. Data mode and zero-feed also meet at a frame boundary. There the bench switches `zero_i` on the very strobe after the last data bit, and compares the seven serial samples with the table value.

// File: rtl/crc7_pkg.sv
package crc7_pkg;
  localparam int unsigned CRC_W = 7;
  localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;  // x^7 + x^3 + 1, x^7 implicit

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_CLEAR = 2'd1,
    OP_DATA  = 2'd2,
    OP_FLUSH = 2'd3
  } crc_op_e;
endpackage

// File: rtl/crc7_op_decode.sv
module crc7_op_decode
  import crc7_pkg::*;
(
  input  logic    clr_i,
  input  logic    en_i,
  input  logic    zero_i,
  output crc_op_e op_o
);
  always_comb begin
    if (clr_i)       op_o = OP_CLEAR;
    else if (!en_i)  op_o = OP_HOLD;
    else if (zero_i) op_o = OP_FLUSH;
    else             op_o = OP_DATA;
  end
endmodule

// File: rtl/crc7_lfsr.sv
module crc7_lfsr
  import crc7_pkg::*;
#(
  parameter int unsigned       W    = CRC_W,
  parameter logic [W-1:0]      POLY = CRC_POLY
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  crc_op_e      op_i,
  input  logic         bit_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] state_q, step_d;
  logic         fb;

  // feedback is gated off in flush mode, turning the register into a plain shifter
  assign fb = (op_i == OP_DATA) ? (bit_i ^ state_q[W-1]) : 1'b0;

  for (genvar s = 0; s < W; s++) begin : g_stage
    if (s == 0) begin : g_head
      assign step_d[s] = fb;
    end else if (POLY[s]) begin : g_tap
      assign step_d[s] = state_q[s-1] ^ fb;
    end else begin : g_pass
      assign step_d[s] = state_q[s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= '0;
    end else begin
      unique case (op_i)
        OP_CLEAR: state_q <= '0;
        OP_DATA,
        OP_FLUSH: state_q <= step_d;
        default:  state_q <= state_q;
      endcase
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/crc7_serial_unit.sv
module crc7_serial_unit
  import crc7_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic             zero_i,
  input  logic             bit_i,
  output logic             ser_o,
  output logic [CRC_W-1:0] crc_o
);
  crc_op_e          op;
  logic [CRC_W-1:0] state;

  crc7_op_decode i_decode (
    .clr_i  (clr_i),
    .en_i   (en_i),
    .zero_i (zero_i),
    .op_o   (op)
  );

  crc7_lfsr #(
    .W    (CRC_W),
    .POLY (CRC_POLY)
  ) i_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .op_i    (op),
    .bit_i   (bit_i),
    .state_o (state)
  );

  assign crc_o = state;
  assign ser_o = state[CRC_W-1];
endmodule

// File: rtl/crc7_serial_chk.sv
module crc7_serial_chk
  import crc7_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_i,
  input logic             en_i,
  input logic             zero_i,
  input logic             bit_i,
  input logic             ser_o,
  input logic [CRC_W-1:0] crc_o
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_zero_r1: assert (crc_o == '0 && ser_o == 1'b0)
        else $error("p_reset_zero_r1");
    end
  end

  p_data_lsb_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && en_i && !zero_i) |=> crc_o[0] == ($past(bit_i) ^ $past(crc_o[CRC_W-1])));

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !en_i) |=> $stable(crc_o));

  p_clear_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> crc_o == '0);

  p_flush_shift_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && en_i && zero_i) |=> crc_o == {$past(crc_o[CRC_W-2:0]), 1'b0});

  p_flush_emit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && en_i && zero_i) |=> $past(crc_o[CRC_W-2]) == ser_o);
endmodule

bind crc7_serial_unit crc7_serial_chk i_chk (.*);

// File: tb/test_crc7_serial_unit.sv
`timescale 1ns/1ps
module test_crc7_serial_unit;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       clr_i = 1'b0, en_i = 1'b0, zero_i = 1'b0, bit_i = 1'b0;
  logic       ser_o;
  logic [6:0] crc_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk_i = ~clk_i;

  crc7_serial_unit i_crc7_serial_unit (.*);

  typedef struct packed { logic [39:0] msg; logic [6:0] crc; } vec_t;
  localparam int NVEC = 4;
  localparam vec_t VECS [NVEC] = '{
    '{40'h4000000000, 7'h4A},
    '{40'h48000001AA, 7'h43},
    '{40'h5100000000, 7'h2A},
    '{40'h7700000000, 7'h32}
  };

  function automatic logic [6:0] ref_crc(input logic [39:0] m);
    logic [6:0] r = '0;
    for (int i = 39; i >= 0; i--) begin
      logic f = m[i] ^ r[6];
      r = {r[5:0], 1'b0};
      if (f) r = r ^ 7'h09;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [6:0] act, input logic [6:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic en, input logic zero, input logic clr, input logic b);
    @(negedge clk_i);
    en_i = en; zero_i = zero; clr_i = clr; bit_i = b;
    @(posedge clk_i);
    #1;
  endtask

  task automatic feed(input logic [39:0] m);
    drive(1'b0, 1'b0, 1'b1, 1'b0);
    for (int i = 39; i >= 0; i--) drive(1'b1, 1'b0, 1'b0, m[i]);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [6:0] got, snap;
    logic [39:0] m;
    #1;
    check("R1 in reset", {ser_o, crc_o[5:0]}, 7'h00);
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 after release", crc_o, 7'h00);
    check("R1 ser", {6'b0, ser_o}, 7'h00);

    for (int v = 0; v < NVEC; v++) begin
      drive(1'b0, 1'b0, 1'b1, 1'b0);
      for (int i = 39; i >= 1; i--) drive(1'b1, 1'b0, 1'b0, VECS[v].msg[i]);
      snap = crc_o;
      @(negedge clk_i);
      en_i = 1'b1; zero_i = 1'b0; bit_i = VECS[v].msg[0];
      #1;
      check("R3 not before edge", crc_o, snap);
      @(posedge clk_i); #1;
      check("R2 table", crc_o, VECS[v].crc);
      check("R7 ser is top", {6'b0, ser_o}, {6'b0, crc_o[6]});
      // flush on the very next strobe
      for (int k = 6; k >= 0; k--) begin
        got[k] = ser_o;
        drive(1'b1, 1'b1, 1'b0, 1'b0);
      end
      check("R7 serial MSB first", got, VECS[v].crc);
      check("R6 empty after 7", crc_o, 7'h00);
    end

    for (int n = 0; n < 6; n++) begin
      m = {$urandom, $urandom} & 40'hFF_FFFF_FFFF;
      feed(m);
      check("R2 model", crc_o, ref_crc(m));
      got = crc_o;
      drive(1'b1, 1'b1, 1'b0, 1'b1);
      check("R6 one shift", crc_o, {got[5:0], 1'b0});
      feed(m);
      for (int k = 6; k >= 0; k--) drive(1'b1, 1'b0, 1'b0, got[k]);
      check("R8 residue", crc_o, 7'h00);
    end

    feed(40'h48000001AA);
    for (int k = 0; k < 5; k++) begin
      drive(1'b0, k[0], 1'b0, ~k[1]);
      check("R4 hold", crc_o, 7'h43);
      check("R4 ser hold", {6'b0, ser_o}, 7'h01);
    end

    feed(40'h48000001AA);
    drive(1'b1, 1'b0, 1'b1, 1'b1);
    check("R5 clear over data", crc_o, 7'h00);
    feed(40'h48000001AA);
    drive(1'b1, 1'b1, 1'b1, 1'b0);
    check("R5 clear over flush", crc_o, 7'h00);
    feed(40'h4000000000);
    drive(1'b0, 1'b0, 1'b1, 1'b0);
    check("R5 clear alone", crc_o, 7'h00);

    drive(1'b0, 1'b0, 1'b0, 1'b0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule